// File: doc/BRIEF.md
# Receive Buffer with Memory-Mapped Read Window

This block holds bytes that a UART receiver has deserialised in a 1024-byte circular store. Software does not pop bytes one at a time. It reads the unconsumed bytes in place through a word-wide window in the register space. When it has copied a batch out, it hands the space back by writing the number of bytes it has finished with to a release register. The block keeps the fill count and reports it in a status word, split across two fields.

Received bytes come in on a one-cycle valid/data strobe. The host uses a 32-bit register port with a registered read result. A receive-data request is raised while the fill count is at or above a programmable threshold and the request is enabled. Releasing bytes lowers the count, so it clears the request once the count falls below the threshold. A byte that arrives while the store is full is discarded, and a sticky flag records the loss.

Top module: `rx_fifo_window`

## Requirements
- R1: After reset the fill count is 0, the status word (byte address 0x000) and the configuration word (0x808) both read 0, `rxReq` is low and `hostRdata` is 0.
- R2: A pulse on `inValid` while fewer than 1024 bytes are held stores `inData` and adds one to the count. The status word carries count bits [7:0] in bits [31:24] and count bits [9:8] in bits [7:6].
- R3: A read of the word at byte address 0x004+4m returns the bytes at window offsets 4m to 4m+3, with offset 4m+i in bits [8i+7:8i]. Offset 0 is the oldest unconsumed byte. `hostRdata` shows the result from the cycle after the read strobe.
- R4: Writing N to byte address 0x800 (data bits [10:0]) discards the N oldest bytes and lowers the count by N. The next window offset 0 is then the byte that was previously at offset N.
- R5: A release value larger than the current count discards exactly the current count, so the store ends empty.
- R6: A byte that arrives while 1024 bytes are held is dropped and leaves the stored data untouched. It sets the overrun flag in status bit 1.
- R7: Reading the status word returns the overrun flag and then clears it. A drop in the same cycle as the status read leaves the flag set.
- R8: With configuration bit 0 (request enable) set and trigger code k in configuration bits [22:20], `rxReq` is high exactly when the count is at least 2^(k+2). `rxReq` is always low while the enable is clear. Status bit 0 mirrors `rxReq`.
- R9: The 10-bit count field of the status word saturates at 1023 while the store holds 1024 bytes.
- R10: Storage and window addressing wrap modulo 1024, so data that crosses the end of the store reads back in arrival order.
- R11: An arrival and a release in the same cycle both take effect. The release is limited by the count before that cycle, and the new count is the old count minus the released amount plus one.
- R12: Reads from addresses outside the status word, the window and the configuration word return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A received byte is presented this cycle |
| inData | input | 8 | Received byte |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 12 | Host byte address, word aligned |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Registered read data of the last read |
| rxReq | output | 1 | Receive-data request |

## Verification
The assertions assume the inputs are never unknown once reset is released, that host addresses are word aligned, and that the host does not issue a read and a write in the same cycle. Outside the deliberate cases, the increment and clamp properties also assume that an arrival and a release do not share a cycle. The stimulus keeps to these assumptions by driving every access through a task that asserts one strobe at a time, on the falling edge. Arrival and release are combined, and arrival and status read are combined, only in the two dedicated tasks for R11 and R7, and the properties are written to exclude exactly those combinations.

// File: rtl/rxw_pkg.sv
`timescale 1ns/1ps
package rxw_pkg;
  // strobes issued by the control to the storage datapath
  typedef struct packed {
    logic storeByte;  // write the incoming byte at the write index
    logic winLoad;    // capture the four window lanes into the read register
  } rxwStrobe_t;
endpackage

// File: rtl/rxw_data.sv
`timescale 1ns/1ps
module rxw_data
  import rxw_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10,
  parameter int DATA_W     = 8,
  parameter int LANES      = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rxwStrobe_t                strobe,
  input  logic [DEPTH_LOG2-1:0]     wrIdx,
  input  logic [DATA_W-1:0]         inData,
  input  logic [DEPTH_LOG2-1:0]     rdIdx,
  output logic [LANES*DATA_W-1:0]   winWord
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LANES*DATA_W-1:0] laneBytes;

  always_ff @(posedge clk) begin
    if (strobe.storeByte) mem[wrIdx] <= inData;
  end

  // each lane reads the byte at its own wrapped offset from the window base
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [DEPTH_LOG2-1:0] laneIdx;
    assign laneIdx = rdIdx + DEPTH_LOG2'(g);
    assign laneBytes[g*DATA_W +: DATA_W] = mem[laneIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               winWord <= '0;
    else if (strobe.winLoad) winWord <= laneBytes;
  end

  // R2: an accepted byte is in the store on the next cycle
  p_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |=> mem[$past(wrIdx)] == $past(inData));

endmodule

// File: rtl/rxw_ctrl.sv
`timescale 1ns/1ps
module rxw_ctrl
  import rxw_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10,
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LVL_W      = 3,
  parameter int LVL_LSB    = 20,
  parameter int STAT_ADDR  = 'h000,
  parameter int WIN_LO     = 'h004,
  parameter int WIN_HI     = 'h3FF,
  parameter int REL_ADDR   = 'h800,
  parameter int CFG_ADDR   = 'h808
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  hostRd,
  input  logic                  hostWr,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [WORD_W-1:0]     hostWdata,
  output rxwStrobe_t            strobe,
  output logic [DEPTH_LOG2-1:0] wrIdx,
  output logic [DEPTH_LOG2-1:0] rdIdx,
  output logic [WORD_W-1:0]     regWord,
  output logic                  srcWin,
  output logic                  rxReq
);
  localparam int PTR_W   = DEPTH_LOG2;
  localparam int CNT_W   = DEPTH_LOG2 + 1;
  localparam int DEPTH   = 1 << DEPTH_LOG2;
  localparam int FIELD_W = 10;
  localparam int FMAX    = (1 << FIELD_W) - 1;

  logic [CNT_W-1:0] cnt, relReq, relAmt;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             ovr, ie;
  logic [LVL_W-1:0] lvl;

  logic isStat, isWin, isRel, isCfg, relWr, statRd;
  logic full, push, drop;
  logic [ADDR_W-1:0] winOff;
  logic [31:0] thr;
  logic [FIELD_W-1:0] statCnt;
  logic [WORD_W-1:0] statWord, cfgWord;
  logic unusedWdata;

  // address decode
  assign isStat = hostAddr == ADDR_W'(STAT_ADDR);
  assign isWin  = (hostAddr >= ADDR_W'(WIN_LO)) && (hostAddr <= ADDR_W'(WIN_HI));
  assign isRel  = hostAddr == ADDR_W'(REL_ADDR);
  assign isCfg  = hostAddr == ADDR_W'(CFG_ADDR);
  assign relWr  = hostWr && isRel;
  assign statRd = hostRd && isStat;
  assign unusedWdata = ^hostWdata;

  // fill tracking
  assign full   = cnt == CNT_W'(DEPTH);
  assign push   = inValid && !full;
  assign drop   = inValid && full;
  assign relReq = relWr ? hostWdata[CNT_W-1:0] : '0;
  assign relAmt = (relReq > cnt) ? cnt : relReq;

  // window base relative to the oldest byte
  assign winOff = hostAddr - ADDR_W'(WIN_LO);
  assign rdIdx  = rdPtr + winOff[PTR_W-1:0];
  assign wrIdx  = wrPtr;

  assign strobe.storeByte = push;
  assign strobe.winLoad   = hostRd && isWin;

  // trigger threshold 2^(k+2)
  assign thr   = 32'd1 << (32'(lvl) + 32'd2);
  assign rxReq = ie && (32'(cnt) >= thr);

  always_comb begin
    if (32'(cnt) > 32'(FMAX)) statCnt = FIELD_W'(FMAX);
    else                      statCnt = FIELD_W'(cnt);
    statWord        = '0;
    statWord[31:24] = statCnt[7:0];
    statWord[7:6]   = statCnt[9:8];
    statWord[1]     = ovr;
    statWord[0]     = rxReq;
    cfgWord         = '0;
    cfgWord[0]      = ie;
    cfgWord[LVL_LSB +: LVL_W] = lvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      cnt   <= cnt - relAmt + CNT_W'(push);
      wrPtr <= wrPtr + PTR_W'(push);
      rdPtr <= rdPtr + relAmt[PTR_W-1:0];
    end
  end

  // sticky loss flag: a drop wins over the clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ovr <= 1'b0;
    else if (drop)   ovr <= 1'b1;
    else if (statRd) ovr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ie  <= 1'b0;
      lvl <= '0;
    end else if (hostWr && isCfg) begin
      ie  <= hostWdata[0];
      lvl <= hostWdata[LVL_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWord <= '0;
      srcWin  <= 1'b0;
    end else if (hostRd) begin
      srcWin  <= isWin;
      regWord <= isStat ? statWord : (isCfg ? cfgWord : '0);
    end
  end

  // R2: the count never exceeds the store size
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));

  // R2: an accepted byte without a release adds one
  p_push_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !full && !relWr) |=> cnt == $past(cnt) + CNT_W'(1));

  // R6: a byte arriving at full raises the loss flag
  p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && full) |=> ovr);

  // R6: a dropped byte does not move the write pointer
  p_drop_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && full && !relWr) |=> $stable(wrPtr));

  // R5: release limited to the count
  p_rel_clamp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (relWr && !inValid) |=>
      cnt == (($past(hostWdata[CNT_W-1:0]) >= $past(cnt)) ? '0
              : $past(cnt) - $past(hostWdata[CNT_W-1:0])));

  // R7: a status read without a drop leaves the flag clear
  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !drop) |=> !ovr);

endmodule

// File: rtl/rx_fifo_window.sv
`timescale 1ns/1ps
module rx_fifo_window
  import rxw_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              rxReq
);
  localparam int LANES = WORD_W / DATA_W;

  rxwStrobe_t            strobe;
  logic [DEPTH_LOG2-1:0] wrIdx, rdIdx;
  logic [WORD_W-1:0]     regWord, winWord;
  logic                  srcWin;

  rxw_ctrl #(
    .DEPTH_LOG2(DEPTH_LOG2), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .hostRd(hostRd), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .regWord(regWord), .srcWin(srcWin), .rxReq(rxReq)
  );

  rxw_data #(
    .DEPTH_LOG2(DEPTH_LOG2), .DATA_W(DATA_W), .LANES(LANES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .inData(inData), .rdIdx(rdIdx), .winWord(winWord)
  );

  assign hostRdata = srcWin ? winWord : regWord;

endmodule

// File: tb/sim_rx_fifo_window.sv
`timescale 1ns/1ps
module sim_rx_fifo_window;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, inValid, hostRd, hostWr, rxReq;
  logic [7:0]  inData;
  logic [11:0] hostAddr;
  logic [31:0] hostWdata, hostRdata;

  rx_fifo_window u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .hostRd(hostRd), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .rxReq(rxReq)
  );

  int nTests = 0;
  int nFail  = 0;
  int seq    = 0;
  logic [7:0] q[$];
  logic expOvr = 1'b0;
  logic expIe  = 1'b0;
  int   expLvl = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic expReq();
    return expIe && (q.size() >= (1 << (expLvl + 2)));
  endfunction

  function automatic logic [31:0] expStatus();
    int c;
    logic [31:0] s;
    c = (q.size() > 1023) ? 1023 : q.size();
    s = '0;
    s[31:24] = c[7:0];
    s[7:6]   = c[9:8];
    s[1]     = expOvr;
    s[0]     = expReq();
    return s;
  endfunction

  function automatic logic [7:0] patByte(input int n);
    int v;
    v = n * 37 + 11;
    return v[7:0];
  endfunction

  task automatic pushByte();
    logic [7:0] d;
    d = patByte(seq);
    seq++;
    inValid = 1'b1; inData = d;
    @(negedge clk);
    inValid = 1'b0;
    if (q.size() < 1024) q.push_back(d);
    else expOvr = 1'b1;
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [31:0] d);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [11:0] a, output logic [31:0] d);
    hostRd = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRd = 1'b0;
    d = hostRdata;
  endtask

  task automatic readStatus(input string tag);
    logic [31:0] got;
    hostRead(12'h000, got);
    chk(tag, got, expStatus());
    expOvr = 1'b0;
  endtask

  task automatic relBytes(input int n);
    int k;
    hostWrite(12'h800, 32'(n));
    k = (n > q.size()) ? q.size() : n;
    repeat (k) void'(q.pop_front());
  endtask

  task automatic setCfg(input logic en, input int lv);
    logic [31:0] w;
    w = '0;
    w[0] = en;
    w[22:20] = lv[2:0];
    hostWrite(12'h808, w);
    expIe = en; expLvl = lv;
  endtask

  task automatic checkWin(input string tag, input int nWords);
    logic [31:0] got, exp, mask;
    for (int w = 0; w < nWords; w++) begin
      hostRead(12'(4 + 4 * w), got);
      exp = '0; mask = '0;
      for (int i = 0; i < 4; i++) begin
        if (4 * w + i < q.size()) begin
          exp[8*i +: 8]  = q[4 * w + i];
          mask[8*i +: 8] = 8'hFF;
        end
      end
      chk($sformatf("%s word %0d", tag, w), got & mask, exp);
    end
  endtask

  // R11: arrival and release in one cycle
  task automatic pushAndRelease(input int n);
    logic [7:0] d;
    int pre, k;
    d = patByte(seq);
    seq++;
    inValid = 1'b1; inData = d;
    hostWr = 1'b1; hostAddr = 12'h800; hostWdata = 32'(n);
    @(negedge clk);
    inValid = 1'b0; hostWr = 1'b0;
    pre = q.size();
    k = (n > pre) ? pre : n;
    repeat (k) void'(q.pop_front());
    if (pre < 1024) q.push_back(d);
    else expOvr = 1'b1;
  endtask

  // R7: drop coinciding with a status read
  task automatic pushAndStat(output logic [31:0] got);
    logic [7:0] d;
    d = patByte(seq);
    seq++;
    inValid = 1'b1; inData = d;
    hostRd = 1'b1; hostAddr = 12'h000;
    @(negedge clk);
    inValid = 1'b0; hostRd = 1'b0;
    got = hostRdata;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion of all requirements");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] got, pre;
    rstN = 1'b0; inValid = 1'b0; inData = '0;
    hostRd = 1'b0; hostWr = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", hostRdata, 32'h0);
    chk("R1 rxReq", 32'(rxReq), 32'h0);
    readStatus("R1 status");
    hostRead(12'h808, got);
    chk("R1 config", got, 32'h0);

    // R2 / R3 small fill
    repeat (5) pushByte();
    readStatus("R2 status after 5");
    checkWin("R3 window", 2);

    // R4 release
    relBytes(3);
    readStatus("R4 status after release");
    checkWin("R4 window", 1);

    // R8 sweep of every trigger code across counts 2..520
    while (q.size() <= 520) begin
      for (int lv = 0; lv < 8; lv++) begin
        setCfg(1'b1, lv);
        chk($sformatf("R8 lvl=%0d cnt=%0d", lv, q.size()), 32'(rxReq), 32'(expReq()));
      end
      setCfg(1'b0, 7);
      chk($sformatf("R8 disabled cnt=%0d", q.size()), 32'(rxReq), 32'h0);
      pushByte();
    end
    readStatus("R2 status after sweep");

    // fill to full, crossing the end of the store
    while (q.size() < 1024) pushByte();
    setCfg(1'b1, 7);
    readStatus("R9 saturated count");
    chk("R8 full lvl7", 32'(rxReq), 32'h1);
    hostRead(12'h808, got);
    chk("R8 config readback", got, 32'h0070_0001);

    // R6 drops at full
    repeat (3) pushByte();
    checkWin("R6 R10 full window", 255);
    readStatus("R7 status shows overrun");
    readStatus("R7 overrun cleared");

    // R7 drop in the same cycle as a status read
    pre = expStatus();
    pushAndStat(got);
    chk("R7 read during drop", got, pre);
    expOvr = 1'b1;
    readStatus("R7 drop wins over clear");

    // R5 clamp
    relBytes(2000);
    readStatus("R5 empty after clamp");
    chk("R5 rxReq low", 32'(rxReq), 32'h0);

    // R10 wrap after refill
    repeat (20) pushByte();
    readStatus("R10 status");
    checkWin("R10 window", 5);

    // R11 combined arrival and release
    pushAndRelease(4);
    readStatus("R11 status small release");
    checkWin("R11 window", 5);
    pushAndRelease(100);
    readStatus("R11 status clamped release");
    checkWin("R11 window after clamp", 1);

    // R12 unmapped space
    repeat (6) pushByte();
    hostWrite(12'h900, 32'hFFFF_FFFF);
    hostRead(12'h900, got);
    chk("R12 unmapped read", got, 32'h0);
    readStatus("R12 status unchanged");
    checkWin("R12 window unchanged", 2);

    summary();
    $finish;
  end
endmodule